// File: doc/BRIEF.md
# Virtual-Channel Link Packetizer and Depacketizer

This block turns channel-tagged messages into flits for a fixed-width physical link, and turns flits back into messages at the far end. The transmit half accepts one message at a time through a valid/ready handshake. It emits a header flit, followed by any body flits, on a valid/ready flit port. The receive half takes those flits from a valid/ready flit port and rebuilds the message. It then presents the message on its own valid/ready output.

Every packet starts with a header carrying a body-flit count, a packet kind (data or credit) and a virtual channel number. A message marked as short carries only as many payload bits as fit beside the header, so the whole packet is one flit. A full-width message is cut into link-width slices that follow the header. The receiver puts those slices back together in their original positions. Choosing the route is left to the surrounding fabric. The two halves share a clock and reset and are otherwise independent.

Top module: `link_flit_codec`

## Requirements
- R1: After reset, no flit is offered (`tx_flit_vld`=0), no message is presented (`rx_msg_vld`=0), and both `tx_msg_rdy` and `rx_flit_rdy` are 1.
- R2: The header occupies the low bits of a flit. Bits [2:0] hold the body-flit count. Bit [3] holds the kind: 0 for data, 1 for credit. Bits [5:4] hold the virtual channel.
- R3: A short message goes out as one flit with count 0, and payload bits [25:0] sit in flit bits [31:6].
- R4: A full-width 64-bit message goes out as a header with count 2 and zero in bits [31:6]. It is followed by two body flits, the first carrying payload bits [31:0] and the second bits [63:32].
- R5: The body flits of a packet follow its header directly, with no flit of another message between them.
- R6: While `tx_flit_vld` is 1 and `tx_flit_rdy` is 0, the flit offered holds its value.
- R7: The receiver presents the original channel, kind and short flag. The payload is the full 64 bits for a full message, and payload bits [25:0] zero-extended for a short one.
- R8: `rx_msg_vld` rises only in the cycle after the last flit of a packet is taken, never after a header that announces body flits or after a body flit that is not the last.
- R9: While a rebuilt message waits on `rx_msg_rdy`=0, `rx_flit_rdy` is 0 and the presented message holds its value.
- R10: Messages come out of the receiver in the order they entered the transmitter.
- R11: Credit-kind messages pass through with the kind bit set end to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_msg_vld | input | 1 | Message offered to the packetizer |
| tx_msg_rdy | output | 1 | Packetizer takes the message |
| tx_msg_vc | input | VC_W | Virtual channel of the message |
| tx_msg_kind | input | 1 | 0 data, 1 credit |
| tx_msg_short | input | 1 | Message fits in a single combined flit |
| tx_msg_data | input | PAY_W | Message payload |
| tx_flit_vld | output | 1 | Flit offered to the link |
| tx_flit_rdy | input | 1 | Link takes the flit |
| tx_flit | output | LINK_W | Outgoing flit |
| rx_flit_vld | input | 1 | Flit offered from the link |
| rx_flit_rdy | output | 1 | Depacketizer takes the flit |
| rx_flit | input | LINK_W | Incoming flit |
| rx_msg_vld | output | 1 | Rebuilt message presented |
| rx_msg_rdy | input | 1 | Consumer takes the message |
| rx_msg_vc | output | VC_W | Virtual channel of the rebuilt message |
| rx_msg_kind | output | 1 | Kind of the rebuilt message |
| rx_msg_short | output | 1 | Message arrived as a combined flit |
| rx_msg_data | output | PAY_W | Rebuilt payload |

## Verification
The receive-side checks assume that incoming flits are well formed. Every header announces either zero body flits or exactly the number a full payload needs, and the body flits arrive in order after their header. The bench guarantees this by looping the transmitter's flit port straight into the receiver. Where the link is to stall, it gates the handshake on both sides together, so a flit is neither dropped nor duplicated. The assertions also assume that the neighbours keep the valid/ready contract: an offered flit or message is not withdrawn. Every bench task drives a value at a falling edge and holds it until the handshake completes.

// File: rtl/link_pkt_pkg.sv
package link_pkt_pkg;

   typedef enum logic {
      KIND_DATA   = 1'b0,
      KIND_CREDIT = 1'b1
   } pkt_kind_e;

   typedef enum logic {
      RX_HEAD = 1'b0,
      RX_BODY = 1'b1
   } rx_state_e;

   function automatic int unsigned slices_for(input int unsigned bits, input int unsigned lane);
      return (bits + lane - 1) / lane;
   endfunction

endpackage

// File: rtl/link_pkt_tx.sv
module link_pkt_tx
   import link_pkt_pkg::*;
#(
   parameter int unsigned LINK_W = 32,
   parameter int unsigned PAY_W  = 64,
   parameter int unsigned VC_W   = 2,
   parameter int unsigned LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   output logic              in_rdy,
   input  logic [VC_W-1:0]   in_vc,
   input  pkt_kind_e         in_kind,
   input  logic              in_short,
   input  logic [PAY_W-1:0]  in_data,
   output logic              flit_vld,
   input  logic              flit_rdy,
   output logic [LINK_W-1:0] flit
);

   localparam int unsigned HDR_W   = LEN_W + 1 + VC_W;
   localparam int unsigned SHORT_W = LINK_W - HDR_W;
   localparam int unsigned NBODY   = slices_for(PAY_W, LINK_W);
   localparam int unsigned PAD_W   = NBODY * LINK_W;
   localparam int unsigned BEAT_W  = $clog2(NBODY + 1);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NBODY);
   localparam logic [LEN_W-1:0]  BODY_LEN  = LEN_W'(NBODY);

   initial begin
      if (LINK_W <= HDR_W)
         $fatal(1, "link_pkt_tx: link too narrow for the header");
      if (NBODY >= (1 << LEN_W))
         $fatal(1, "link_pkt_tx: count field cannot hold the body-flit count");
      if (PAY_W <= SHORT_W)
         $fatal(1, "link_pkt_tx: payload never needs body flits");
   end

   logic              busy;
   logic [BEAT_W-1:0] beat;
   logic [VC_W-1:0]   h_vc;
   pkt_kind_e         h_kind;
   logic              h_short;
   logic [PAD_W-1:0]  h_data;

   logic              last;
   logic              accept;
   logic              fire;
   logic [LINK_W-1:0] hdr_flit;
   logic [LINK_W-1:0] body_flit;
   logic [SHORT_W-1:0] hdr_pay;

   assign last   = h_short ? (beat == '0) : (beat == LAST_BEAT);
   assign fire   = busy && flit_rdy;
   assign in_rdy = !busy || (last && flit_rdy);
   assign accept = in_vld && in_rdy;

   assign hdr_pay  = h_short ? h_data[SHORT_W-1:0] : '0;
   assign hdr_flit = {hdr_pay, h_vc, h_kind, (h_short ? '0 : BODY_LEN)};

   always_comb begin
      body_flit = '0;
      for (int i = 0; i < NBODY; i++) begin
         if (beat == BEAT_W'(i + 1))
            body_flit = h_data[i*LINK_W +: LINK_W];
      end
   end

   assign flit_vld = busy;
   assign flit     = (beat == '0) ? hdr_flit : body_flit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         beat    <= '0;
         h_vc    <= '0;
         h_kind  <= KIND_DATA;
         h_short <= 1'b0;
         h_data  <= '0;
      end else if (accept) begin
         busy    <= 1'b1;
         beat    <= '0;
         h_vc    <= in_vc;
         h_kind  <= in_kind;
         h_short <= in_short;
         h_data  <= PAD_W'(in_data);
      end else if (fire) begin
         if (last) begin
            busy <= 1'b0;
            beat <= '0;
         end else begin
            beat <= beat + 1'b1;
         end
      end
   end

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_vld && !flit_rdy) |=> (flit_vld && $stable(flit))); // R6

   AST_TX_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_vld && flit_rdy && !last) |=> (flit_vld && beat == $past(beat) + 1'b1)); // R5

   AST_TX_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      beat <= LAST_BEAT); // R4

endmodule

// File: rtl/link_pkt_rx.sv
module link_pkt_rx
   import link_pkt_pkg::*;
#(
   parameter int unsigned LINK_W = 32,
   parameter int unsigned PAY_W  = 64,
   parameter int unsigned VC_W   = 2,
   parameter int unsigned LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flit_vld,
   output logic              flit_rdy,
   input  logic [LINK_W-1:0] flit,
   output logic              out_vld,
   input  logic              out_rdy,
   output logic [VC_W-1:0]   out_vc,
   output pkt_kind_e         out_kind,
   output logic              out_short,
   output logic [PAY_W-1:0]  out_data
);

   localparam int unsigned HDR_W   = LEN_W + 1 + VC_W;
   localparam int unsigned NBODY   = slices_for(PAY_W, LINK_W);
   localparam int unsigned PAD_W   = NBODY * LINK_W;
   localparam int unsigned BEAT_W  = $clog2(NBODY + 1);
   localparam logic [LEN_W-1:0] BODY_LEN = LEN_W'(NBODY);

   initial begin
      if (LINK_W <= HDR_W)
         $fatal(1, "link_pkt_rx: link too narrow for the header");
      if (NBODY >= (1 << LEN_W))
         $fatal(1, "link_pkt_rx: count field cannot hold the body-flit count");
   end

   rx_state_e         st;
   logic [LEN_W-1:0]  remain;
   logic [BEAT_W-1:0] idx;
   logic [PAD_W-1:0]  acc;
   logic              take;
   logic [LEN_W-1:0]  f_len;

   assign flit_rdy = !out_vld;
   assign take     = flit_vld && flit_rdy;
   assign f_len    = flit[LEN_W-1:0];
   assign out_data = acc[PAY_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= RX_HEAD;
         remain    <= '0;
         idx       <= '0;
         acc       <= '0;
         out_vld   <= 1'b0;
         out_vc    <= '0;
         out_kind  <= KIND_DATA;
         out_short <= 1'b0;
      end else begin
         if (out_vld && out_rdy)
            out_vld <= 1'b0;
         if (take) begin
            if (st == RX_HEAD) begin
               out_vc   <= flit[HDR_W-1:LEN_W+1];
               out_kind <= pkt_kind_e'(flit[LEN_W]);
               if (f_len == '0) begin
                  acc       <= PAD_W'(flit[LINK_W-1:HDR_W]);
                  out_short <= 1'b1;
                  out_vld   <= 1'b1;
               end else begin
                  acc       <= '0;
                  out_short <= 1'b0;
                  remain    <= f_len;
                  idx       <= '0;
                  st        <= RX_BODY;
               end
            end else begin
               for (int i = 0; i < NBODY; i++) begin
                  if (idx == BEAT_W'(i))
                     acc[i*LINK_W +: LINK_W] <= flit;
               end
               idx    <= idx + 1'b1;
               remain <= remain - 1'b1;
               if (remain == LEN_W'(1)) begin
                  out_vld <= 1'b1;
                  st      <= RX_HEAD;
               end
            end
         end
      end
   end

   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_rdy) |=> (out_vld && $stable(out_data) && $stable(out_vc) && !flit_rdy)); // R9

   AST_RX_DONE_ON_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_vld) |-> $past(flit_vld && flit_rdy)); // R8

   AST_RX_LEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (take && st == RX_HEAD) |-> (f_len == '0 || f_len == BODY_LEN)); // R4

endmodule

// File: rtl/link_flit_codec.sv
module link_flit_codec
   import link_pkt_pkg::*;
#(
   parameter int unsigned LINK_W = 32,
   parameter int unsigned PAY_W  = 64,
   parameter int unsigned VC_W   = 2,
   parameter int unsigned LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_msg_vld,
   output logic              tx_msg_rdy,
   input  logic [VC_W-1:0]   tx_msg_vc,
   input  logic              tx_msg_kind,
   input  logic              tx_msg_short,
   input  logic [PAY_W-1:0]  tx_msg_data,
   output logic              tx_flit_vld,
   input  logic              tx_flit_rdy,
   output logic [LINK_W-1:0] tx_flit,
   input  logic              rx_flit_vld,
   output logic              rx_flit_rdy,
   input  logic [LINK_W-1:0] rx_flit,
   output logic              rx_msg_vld,
   input  logic              rx_msg_rdy,
   output logic [VC_W-1:0]   rx_msg_vc,
   output logic              rx_msg_kind,
   output logic              rx_msg_short,
   output logic [PAY_W-1:0]  rx_msg_data
);

   pkt_kind_e rx_kind_e;

   link_pkt_tx #(.LINK_W(LINK_W), .PAY_W(PAY_W), .VC_W(VC_W), .LEN_W(LEN_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (tx_msg_vld),
      .in_rdy   (tx_msg_rdy),
      .in_vc    (tx_msg_vc),
      .in_kind  (pkt_kind_e'(tx_msg_kind)),
      .in_short (tx_msg_short),
      .in_data  (tx_msg_data),
      .flit_vld (tx_flit_vld),
      .flit_rdy (tx_flit_rdy),
      .flit     (tx_flit)
   );

   link_pkt_rx #(.LINK_W(LINK_W), .PAY_W(PAY_W), .VC_W(VC_W), .LEN_W(LEN_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .flit_vld  (rx_flit_vld),
      .flit_rdy  (rx_flit_rdy),
      .flit      (rx_flit),
      .out_vld   (rx_msg_vld),
      .out_rdy   (rx_msg_rdy),
      .out_vc    (rx_msg_vc),
      .out_kind  (rx_kind_e),
      .out_short (rx_msg_short),
      .out_data  (rx_msg_data)
   );

   assign rx_msg_kind = rx_kind_e;

endmodule

// File: tb/link_flit_codec_bench.sv
module link_flit_codec_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_msg_vld = 1'b0;
   logic        tx_msg_rdy;
   logic [1:0]  tx_msg_vc = '0;
   logic        tx_msg_kind = 1'b0;
   logic        tx_msg_short = 1'b0;
   logic [63:0] tx_msg_data = '0;
   logic        tx_flit_vld;
   logic        tx_flit_rdy;
   logic [31:0] tx_flit;
   logic        rx_flit_vld;
   logic        rx_flit_rdy;
   logic        rx_msg_vld;
   logic        rx_msg_rdy = 1'b1;
   logic [1:0]  rx_msg_vc;
   logic        rx_msg_kind;
   logic        rx_msg_short;
   logic [63:0] rx_msg_data;
   logic        link_stall = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rx_flit_vld = tx_flit_vld && !link_stall;
   assign tx_flit_rdy = rx_flit_rdy && !link_stall;

   link_flit_codec u_link_flit_codec (
      .clk(clk), .rst_n(rst_n),
      .tx_msg_vld(tx_msg_vld), .tx_msg_rdy(tx_msg_rdy), .tx_msg_vc(tx_msg_vc),
      .tx_msg_kind(tx_msg_kind), .tx_msg_short(tx_msg_short), .tx_msg_data(tx_msg_data),
      .tx_flit_vld(tx_flit_vld), .tx_flit_rdy(tx_flit_rdy), .tx_flit(tx_flit),
      .rx_flit_vld(rx_flit_vld), .rx_flit_rdy(rx_flit_rdy), .rx_flit(tx_flit),
      .rx_msg_vld(rx_msg_vld), .rx_msg_rdy(rx_msg_rdy), .rx_msg_vc(rx_msg_vc),
      .rx_msg_kind(rx_msg_kind), .rx_msg_short(rx_msg_short), .rx_msg_data(rx_msg_data)
   );

   // link and receive monitors
   logic [31:0] flog [0:255];
   int          fcnt = 0;
   logic [63:0] r_data [0:63];
   logic [1:0]  r_vc [0:63];
   logic        r_kind [0:63];
   logic        r_short [0:63];
   int          rcnt = 0;

   always @(posedge clk) begin
      if (rst_n && tx_flit_vld && tx_flit_rdy) begin
         flog[fcnt] <= tx_flit;
         fcnt <= fcnt + 1;
      end
      if (rst_n && rx_msg_vld && rx_msg_rdy) begin
         r_data[rcnt]  <= rx_msg_data;
         r_vc[rcnt]    <= rx_msg_vc;
         r_kind[rcnt]  <= rx_msg_kind;
         r_short[rcnt] <= rx_msg_short;
         rcnt <= rcnt + 1;
      end
   end

   // expected messages
   logic [63:0] e_data [0:63];
   logic [1:0]  e_vc [0:63];
   logic        e_kind [0:63];
   logic        e_short [0:63];
   int          nsent = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_hdr(input logic [2:0] len, input logic kind,
                                          input logic [1:0] vc, input logic [25:0] up);
      return {up, vc, kind, len};
   endfunction

   function automatic logic [63:0] rx_expect(input int k);
      return e_short[k] ? {38'd0, e_data[k][25:0]} : e_data[k];
   endfunction

   task automatic send(input logic [1:0] vc, input logic kind, input logic sh, input logic [63:0] d);
      @(negedge clk);
      tx_msg_vld = 1'b1; tx_msg_vc = vc; tx_msg_kind = kind;
      tx_msg_short = sh; tx_msg_data = d;
      while (!tx_msg_rdy) @(negedge clk);
      e_data[nsent] = d; e_vc[nsent] = vc; e_kind[nsent] = kind; e_short[nsent] = sh;
      nsent++;
      @(posedge clk);
      #1 tx_msg_vld = 1'b0;
   endtask

   task automatic drain(input string tag);
      int n = 0;
      while (rcnt != nsent && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " drain count"}, 64'(rcnt), 64'(nsent));
   endtask

   task automatic chk_rx(input int k, input string tag);
      chk({tag, " data"},  r_data[k], rx_expect(k));
      chk({tag, " vc"},    64'(r_vc[k]), 64'(e_vc[k]));
      chk({tag, " kind"},  64'(r_kind[k]), 64'(e_kind[k]));
      chk({tag, " short"}, 64'(r_short[k]), 64'(e_short[k]));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 tx_flit_vld", 64'(tx_flit_vld), 64'd0);
      chk("R1 rx_msg_vld",  64'(rx_msg_vld), 64'd0);
      chk("R1 tx_msg_rdy",  64'(tx_msg_rdy), 64'd1);
      chk("R1 rx_flit_rdy", 64'(rx_flit_rdy), 64'd1);
   endtask

   task automatic t_short();
      int f = fcnt;
      int k = nsent;
      send(2'd1, 1'b0, 1'b1, 64'hFFFF_0000_02AB_CDEF);
      drain("R3 short");
      chk("R3 flit count", 64'(fcnt - f), 64'd1);
      chk("R2 R3 combined flit", 64'(flog[f]), 64'(mk_hdr(3'd0, 1'b0, 2'd1, 26'h2AB_CDEF)));
      chk_rx(k, "R7 short");
   endtask

   task automatic t_wide();
      int f = fcnt;
      int k = nsent;
      send(2'd2, 1'b0, 1'b0, 64'hDEAD_BEEF_1234_5678);
      drain("R4 wide");
      chk("R4 flit count", 64'(fcnt - f), 64'd3);
      chk("R2 R4 header", 64'(flog[f]), 64'(mk_hdr(3'd2, 1'b0, 2'd2, 26'd0)));
      chk("R4 body0 low slice", 64'(flog[f+1]), 64'h1234_5678);
      chk("R4 body1 high slice", 64'(flog[f+2]), 64'hDEAD_BEEF);
      chk_rx(k, "R7 wide");
   endtask

   task automatic t_credit();
      int f = fcnt;
      int k = nsent;
      send(2'd3, 1'b1, 1'b1, 64'h15);
      drain("R11 credit");
      chk("R11 credit flit", 64'(flog[f]), 64'(mk_hdr(3'd0, 1'b1, 2'd3, 26'h15)));
      chk_rx(k, "R11 credit rx");
   endtask

   task automatic t_stream();
      int f = fcnt;
      int k0 = nsent;
      int p;
      send(2'd0, 1'b0, 1'b0, 64'h0102_0304_0506_0708);
      send(2'd1, 1'b0, 1'b1, 64'h0000_0000_0000_0ABC);
      send(2'd2, 1'b1, 1'b0, 64'hA5A5_5A5A_F0F0_0F0F);
      send(2'd3, 1'b0, 1'b0, 64'h1111_2222_3333_4444);
      send(2'd0, 1'b1, 1'b1, 64'h0000_0000_03FF_FFFF);
      send(2'd1, 1'b0, 1'b1, 64'h0000_0000_0000_0001);
      drain("R10 stream");
      for (int k = k0; k < nsent; k++) chk_rx(k, "R10 in order");
      p = f;
      for (int k = k0; k < nsent; k++) begin
         if (e_short[k]) begin
            chk("R5 combined flit", 64'(flog[p]),
                64'(mk_hdr(3'd0, e_kind[k], e_vc[k], e_data[k][25:0])));
            p += 1;
         end else begin
            chk("R5 header", 64'(flog[p]), 64'(mk_hdr(3'd2, e_kind[k], e_vc[k], 26'd0)));
            chk("R5 body0 follows header", 64'(flog[p+1]), 64'(e_data[k][31:0]));
            chk("R5 body1 follows body0", 64'(flog[p+2]), 64'(e_data[k][63:32]));
            p += 3;
         end
      end
      chk("R5 total flits", 64'(fcnt), 64'(p));
   endtask

   task automatic t_stall();
      int k = nsent;
      int n = 0;
      logic [63:0] held;
      rx_msg_rdy = 1'b0;
      send(2'd2, 1'b0, 1'b0, 64'h7777_8888_9999_AAAA);
      while (!rx_msg_vld && n < 50) begin @(negedge clk); n++; end
      chk("R9 message presented", 64'(rx_msg_vld), 64'd1);
      chk("R9 flit ready low while stalled", 64'(rx_flit_rdy), 64'd0);
      held = rx_msg_data;
      send(2'd1, 1'b1, 1'b1, 64'h0000_0000_0123_4567);
      repeat (5) @(negedge clk);
      chk("R6 flit still offered", 64'(tx_flit_vld), 64'd1);
      chk("R6 flit held", 64'(tx_flit), 64'(mk_hdr(3'd0, 1'b1, 2'd1, 26'h123_4567)));
      chk("R9 message held", rx_msg_data, held);
      chk("R9 still valid", 64'(rx_msg_vld), 64'd1);
      chk("R9 nothing consumed", 64'(rcnt), 64'(k));
      rx_msg_rdy = 1'b1;
      drain("R9 release");
      chk_rx(k, "R9 first after stall");
      chk_rx(k + 1, "R10 second after stall");
   endtask

   task automatic t_partial();
      int f = fcnt;
      int k = nsent;
      int n = 0;
      send(2'd0, 1'b0, 1'b0, 64'hCAFE_F00D_BAAD_C0DE);
      while (fcnt < f + 1 && n < 50) begin @(negedge clk); n++; end
      link_stall = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8 no message after header only", 64'(rx_msg_vld), 64'd0);
      link_stall = 1'b0;
      @(posedge clk);
      @(negedge clk);
      link_stall = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 one body flit taken", 64'(fcnt - f), 64'd2);
      chk("R8 no message before last body", 64'(rx_msg_vld), 64'd0);
      link_stall = 1'b0;
      drain("R8 partial");
      chk_rx(k, "R8 R7 rebuilt");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_short();
      t_wide();
      t_credit();
      t_stream();
      t_stall();
      t_partial();
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule